// File: doc/BRIEF.md
# Fixed-Block Serial Scratch DMA

This engine copies one fixed block of bytes (64 by default) between byte-addressed main memory and a small scratch buffer used by a serial controller agent. Software first loads a 32-bit memory address, then fires one of two start strobes. The strobe picks the direction: scratch-to-memory (outbound) or memory-to-scratch (inbound). When the engine accepts a start, it clears the low three bits of the address register and keeps that cleared value, so later reads of the register show the base actually used. Main-memory bytes are addressed with the running position XOR 3.

The address is treated as signed. If a byte position in the block is negative, an inbound copy writes zero into the scratch byte, and an outbound copy skips that memory write. A request whose raw signed address is greater than the configured memory size is dropped completely.

An external agent processes the scratch buffer through a request/acknowledge handshake. In the outbound direction the handshake runs before the copy, so the agent can fill the buffer first. In the inbound direction it runs after the copy, so the agent sees the filled buffer. At the end of a transfer the engine sets a sticky status bit and gives a one-cycle pulse to a shared interrupt controller.

Top module: `sdma_top`

## Requirements
- R1: An accepted transfer walks exactly 64 byte positions. Inbound, it makes 64 scratch writes at scratch indices 0 to 63 in rising order. Outbound, it makes one memory write for each non-negative position.
- R2: When a start is accepted, `addr_q` becomes the written address with bits [2:0] cleared, and it holds that value while `busy` is high.
- R3: If `$signed(addr_q) > RAM_BYTES`, a start strobe is dropped. `busy`, `irq_set` and `sts_irq` do not change, and `addr_q` keeps its unaligned value.
- R4: Inbound, scratch byte i receives `mem[(base+i) ^ 3]`, or 0x00 when `base+i` is negative as a 32-bit signed value.
- R5: Outbound, `mem[(base+i) ^ 3]` receives scratch byte i for every non-negative `base+i`. Negative positions cause no memory write.
- R6: Outbound, `proc_req` rises before any copy access. Inbound, it rises only after the 64th scratch write. In both directions `proc_req` stays high, and the engine makes no progress, until `proc_ack` is seen.
- R7: On completion `irq_set` is high for exactly one cycle, `sts_irq` reads 1 from the next cycle, and `busy` falls.
- R8: `sts_clr` clears `sts_irq`. If a completion lands in the same cycle as a clear, the set wins.
- R9: Start strobes and address writes are ignored while `busy` is high. If both start strobes arrive in the same idle cycle, the outbound direction is taken.
- R10: After reset, `busy`, `sts_irq`, `irq_set` and `proc_req` are 0 and `addr_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Load the address register (idle only) |
| addr_wdata | input | 32 | Address value to load |
| addr_q | output | 32 | Current address register |
| go_to_ram | input | 1 | Start strobe, scratch-to-memory |
| go_from_ram | input | 1 | Start strobe, memory-to-scratch |
| busy | output | 1 | Transfer in progress |
| sts_clr | input | 1 | Clear the status interrupt bit |
| sts_irq | output | 1 | Sticky completion status bit |
| irq_set | output | 1 | One-cycle pulse to the shared interrupt flag |
| proc_req | output | 1 | Scratch processing request to the agent |
| proc_ack | input | 1 | Agent acknowledge |
| ram_addr | output | 32 | Main memory byte address |
| ram_re | output | 1 | Main memory read, data valid next cycle |
| ram_we | output | 1 | Main memory byte write |
| ram_wdata | output | 8 | Main memory write data |
| ram_rdata | input | 8 | Main memory read data |
| scr_addr | output | 6 | Scratch byte index |
| scr_re | output | 1 | Scratch read, data valid next cycle |
| scr_we | output | 1 | Scratch byte write |
| scr_wdata | output | 8 | Scratch write data |
| scr_rdata | input | 8 | Scratch read data |

## Verification
A completing transfer and a status clear can hit the status bit in the same cycle. The bench times this after an inbound transfer that ends with the status bit already set. It drops the acknowledge and raises `sts_clr` in the one cycle where the engine is finishing, so the clear and the completion pulse meet. The pass condition is that `sts_irq` reads 1 afterwards, and that a later plain clear then takes it to 0.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HS,
      ST_RD,
      ST_WR,
      ST_FIN
   } sdma_st_e;
endpackage

// File: rtl/sdma_addr.sv
module sdma_addr #(
   parameter int AW        = 32,
   parameter int IW        = 6,
   parameter int RAM_BYTES = 8388608,
   parameter int SWZ       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic          align_en,
   input  logic [IW-1:0] idx,
   output logic [AW-1:0] addr_q,
   output logic          drop,
   output logic          pos_neg,
   output logic [AW-1:0] ram_addr
);
   localparam logic signed [AW-1:0] LIMIT    = AW'(RAM_BYTES);
   localparam logic        [AW-1:0] ALN_MASK = ~AW'(7);

   logic [AW-1:0] pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                addr_q <= '0;
      else if (align_en)         addr_q <= addr_q & ALN_MASK;
      else if (wr_en && !busy)   addr_q <= wr_data;
   end

   assign drop    = $signed(addr_q) > LIMIT;
   assign pos     = addr_q + {{(AW-IW){1'b0}}, idx};
   assign pos_neg = pos[AW-1];

   generate
      if (SWZ == 0) begin : g_plain
         assign ram_addr = pos;
      end else begin : g_swz
         assign ram_addr = pos ^ AW'(SWZ);
      end
   endgenerate

   // R2
   align_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (addr_q[2:0] == 3'b000));
   // R9
   addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
   import sdma_pkg::*;
#(
   parameter int BLK = 64,
   parameter int DW  = 8,
   parameter int IW  = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_to_ram,
   input  logic          go_from_ram,
   input  logic          drop,
   input  logic          pos_neg,
   input  logic          proc_ack,
   input  logic [DW-1:0] ram_rdata,
   input  logic [DW-1:0] scr_rdata,
   output logic          busy,
   output logic          accept,
   output logic          done,
   output logic [IW-1:0] idx,
   output logic          proc_req,
   output logic          ram_re,
   output logic          ram_we,
   output logic [DW-1:0] ram_wdata,
   output logic          scr_re,
   output logic          scr_we,
   output logic [DW-1:0] scr_wdata
);
   localparam logic [IW-1:0] LAST = IW'(BLK - 1);

   sdma_st_e st;
   logic     to_ram_q;
   logic     go_any;
   logic     last;

   assign go_any = go_to_ram | go_from_ram;
   assign accept = (st == ST_IDLE) && go_any && !drop;
   assign last   = (idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         to_ram_q <= 1'b0;
         idx      <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (accept) begin
               to_ram_q <= go_to_ram;
               idx      <= '0;
               st       <= go_to_ram ? ST_HS : ST_RD;
            end
            ST_HS:   if (proc_ack) st <= to_ram_q ? ST_RD : ST_FIN;
            ST_RD:   st <= ST_WR;
            ST_WR: begin
               idx <= idx + 1'b1;
               if (last) st <= to_ram_q ? ST_FIN : ST_HS;
               else      st <= ST_RD;
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FIN);
   assign proc_req  = (st == ST_HS);
   assign scr_re    = (st == ST_RD) && to_ram_q;
   assign ram_re    = (st == ST_RD) && !to_ram_q && !pos_neg;
   assign ram_we    = (st == ST_WR) && to_ram_q && !pos_neg;
   assign scr_we    = (st == ST_WR) && !to_ram_q;
   assign ram_wdata = scr_rdata;
   assign scr_wdata = pos_neg ? '0 : ram_rdata;

   // R6
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proc_req |-> busy);
   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_req && !proc_ack) |=> (proc_req && $stable(idx)));
   // R5
   no_neg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !pos_neg);
   // R1
   one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && scr_we));
endmodule

// File: rtl/sdma_irq.sv
module sdma_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic clr,
   output logic sts_irq,
   output logic irq_set
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sts_irq <= 1'b0;
      else if (done) sts_irq <= 1'b1;
      else if (clr)  sts_irq <= 1'b0;
   end

   assign irq_set = done;

   // R7
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> !irq_set);
   // R7
   sts_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> sts_irq);
   // R8
   clr_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !irq_set) |=> !sts_irq);
endmodule

// File: rtl/sdma_top.sv
module sdma_top #(
   parameter int AW        = 32,
   parameter int DW        = 8,
   parameter int BLK       = 64,
   parameter int RAM_BYTES = 8388608,
   parameter int SWZ       = 3,
   localparam int IW       = $clog2(BLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_we,
   input  logic [AW-1:0] addr_wdata,
   output logic [AW-1:0] addr_q,
   input  logic          go_to_ram,
   input  logic          go_from_ram,
   output logic          busy,
   input  logic          sts_clr,
   output logic          sts_irq,
   output logic          irq_set,
   output logic          proc_req,
   input  logic          proc_ack,
   output logic [AW-1:0] ram_addr,
   output logic          ram_re,
   output logic          ram_we,
   output logic [DW-1:0] ram_wdata,
   input  logic [DW-1:0] ram_rdata,
   output logic [IW-1:0] scr_addr,
   output logic          scr_re,
   output logic          scr_we,
   output logic [DW-1:0] scr_wdata,
   input  logic [DW-1:0] scr_rdata
);
   generate
      if (BLK < 8 || (BLK & (BLK - 1)) != 0) begin : g_bad_blk
         $error("BLK must be a power of two of at least 8");
      end
      if (AW <= IW + 1) begin : g_bad_aw
         $error("AW too narrow for BLK");
      end
      if (SWZ < 0 || SWZ > 7) begin : g_bad_swz
         $error("SWZ must stay inside the aligned 8-byte group");
      end
   endgenerate

   logic          drop, pos_neg, accept, done;
   logic [IW-1:0] idx;

   sdma_addr #(.AW(AW), .IW(IW), .RAM_BYTES(RAM_BYTES), .SWZ(SWZ)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .wr_en    (addr_we),
      .wr_data  (addr_wdata),
      .align_en (accept),
      .idx      (idx),
      .addr_q   (addr_q),
      .drop     (drop),
      .pos_neg  (pos_neg),
      .ram_addr (ram_addr)
   );

   sdma_seq #(.BLK(BLK), .DW(DW), .IW(IW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_to_ram   (go_to_ram),
      .go_from_ram (go_from_ram),
      .drop        (drop),
      .pos_neg     (pos_neg),
      .proc_ack    (proc_ack),
      .ram_rdata   (ram_rdata),
      .scr_rdata   (scr_rdata),
      .busy        (busy),
      .accept      (accept),
      .done        (done),
      .idx         (idx),
      .proc_req    (proc_req),
      .ram_re      (ram_re),
      .ram_we      (ram_we),
      .ram_wdata   (ram_wdata),
      .scr_re      (scr_re),
      .scr_we      (scr_we),
      .scr_wdata   (scr_wdata)
   );

   sdma_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done),
      .clr     (sts_clr),
      .sts_irq (sts_irq),
      .irq_set (irq_set)
   );

   assign scr_addr = idx;

   // R3
   drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && drop) |=> !busy);
endmodule

// File: tb/sdma_top_bench.sv
module sdma_top_bench;
   localparam int RAMB = 256;

   logic        clk = 0, rst_n = 0;
   logic        addr_we = 0, go_to_ram = 0, go_from_ram = 0, sts_clr = 0, proc_ack = 0;
   logic [31:0] addr_wdata = 0;
   logic [31:0] addr_q, ram_addr;
   logic        busy, sts_irq, irq_set, proc_req, ram_re, ram_we, scr_re, scr_we;
   logic [7:0]  ram_wdata, scr_wdata, ram_rdata, scr_rdata;
   logic [5:0]  scr_addr;

   logic        bw_ram_we = 0, bw_scr_we = 0;
   logic [8:0]  bw_addr = 0;
   logic [7:0]  bw_data = 0;
   logic [7:0]  ram_m [0:511];
   logic [7:0]  scr_m [0:63];

   int n_run = 0, n_fail = 0;
   int ram_wc = 0, scr_wc = 0;
   int exp_ra[$], exp_rd[$], exp_sa[$], exp_sd[$], exp_irq[$];
   logic [7:0] exp_s [0:63];
   bit finished = 0;

   always #10 clk = ~clk;

   sdma_top #(.RAM_BYTES(RAMB)) u_sdma_top (
      .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata), .addr_q(addr_q),
      .go_to_ram(go_to_ram), .go_from_ram(go_from_ram), .busy(busy), .sts_clr(sts_clr),
      .sts_irq(sts_irq), .irq_set(irq_set), .proc_req(proc_req), .proc_ack(proc_ack),
      .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .scr_addr(scr_addr), .scr_re(scr_re), .scr_we(scr_we),
      .scr_wdata(scr_wdata), .scr_rdata(scr_rdata)
   );

   always @(posedge clk) begin
      if (ram_re) ram_rdata <= ram_m[ram_addr[8:0]];
      if (ram_we) ram_m[ram_addr[8:0]] <= ram_wdata;
      else if (bw_ram_we) ram_m[bw_addr] <= bw_data;
      if (scr_re) scr_rdata <= scr_m[scr_addr];
      if (scr_we) scr_m[scr_addr] <= scr_wdata;
      else if (bw_scr_we) scr_m[bw_addr[5:0]] <= bw_data;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (ram_we) begin
            ram_wc++;
            if (exp_ra.size() == 0) chk("R5", ram_addr, 32'hDEAD, "unexpected ram write");
            else begin
               chk("R5", ram_addr, exp_ra.pop_front(), "ram write addr");
               chk("R5", {24'h0, ram_wdata}, exp_rd.pop_front(), "ram write data");
            end
         end
         if (scr_we) begin
            scr_wc++;
            if (exp_sa.size() == 0) chk("R4", {26'h0, scr_addr}, 32'hDEAD, "unexpected scr write");
            else begin
               chk("R1", {26'h0, scr_addr}, exp_sa.pop_front(), "scr write index");
               chk("R4", {24'h0, scr_wdata}, exp_sd.pop_front(), "scr write data");
            end
         end
         if (irq_set) begin
            if (exp_irq.size() == 0) chk("R3", 32'h1, 32'h0, "unexpected irq_set");
            else chk("R7", addr_q, exp_irq.pop_front(), "addr at completion");
         end
      end
   end

   task automatic wait_cond(input bit want_req);
      for (int k = 0; k < 2000; k++) begin
         if (want_req ? proc_req : !busy) break;
         @(negedge clk);
      end
   endtask

   task automatic xfer(input bit tr, input logic [31:0] a, input logic [7:0] seed,
                       input bit both, input bit poke, input bit collide);
      logic [31:0] al, pos;
      logic [7:0]  d;
      int negs = 0, r0, s0;
      al = a & 32'hFFFF_FFF8;
      @(negedge clk); addr_we = 1; addr_wdata = a;
      @(negedge clk); addr_we = 0;
      for (int i = 0; i < 64; i++) begin
         pos = al + i;
         if (tr) begin
            if (!pos[31]) begin
               exp_ra.push_back(pos ^ 32'h3);
               exp_rd.push_back(int'(8'(seed + i * 7)));
            end else negs++;
         end else begin
            d = pos[31] ? 8'h00 : ram_m[9'(pos ^ 32'h3)];
            exp_s[i] = d;
            exp_sa.push_back(i);
            exp_sd.push_back(int'(d));
         end
      end
      exp_irq.push_back(al);
      r0 = ram_wc; s0 = scr_wc;
      go_to_ram = tr | both; go_from_ram = !tr | both;
      @(negedge clk); go_to_ram = 0; go_from_ram = 0;
      chk("R2", {31'h0, busy}, 32'h1, "busy after start");
      chk("R2", addr_q, al, "aligned address");
      if (poke) begin
         addr_we = 1; addr_wdata = 32'h55; go_to_ram = 1; go_from_ram = 1;
         @(negedge clk); addr_we = 0; go_to_ram = 0; go_from_ram = 0;
         chk("R9", addr_q, al, "address write while busy");
      end
      wait_cond(1);
      chk("R6", {31'h0, proc_req}, 32'h1, "request seen");
      if (tr) begin
         chk("R6", ram_wc - r0, 0, "no copy before handshake");
         for (int i = 0; i < 64; i++) begin
            bw_scr_we = 1; bw_addr = 9'(i); bw_data = 8'(seed + i * 7);
            @(negedge clk);
         end
         bw_scr_we = 0;
         chk("R6", {31'h0, proc_req}, 32'h1, "request held until ack");
      end else begin
         int bad = 0;
         chk("R6", scr_wc - s0, 64, "copy done before handshake");
         for (int i = 0; i < 64; i++) if (scr_m[i] !== exp_s[i]) bad++;
         chk("R4", bad, 0, "scratch image mismatches");
      end
      proc_ack = 1;
      @(negedge clk); proc_ack = 0;
      if (collide) begin
         sts_clr = 1;
         @(negedge clk); sts_clr = 0;
      end
      wait_cond(0);
      chk("R7", {31'h0, sts_irq}, 32'h1, "status after completion");
      chk("R7", exp_irq.size(), 0, "completion pulse count");
      if (tr) chk("R1", ram_wc - r0, 64 - negs, "ram writes in block");
      else    chk("R1", scr_wc - s0, 64, "scratch writes in block");
   endtask

   task automatic clear_sts();
      @(negedge clk); sts_clr = 1;
      @(negedge clk); sts_clr = 0;
      chk("R8", {31'h0, sts_irq}, 32'h0, "plain clear");
   endtask

   initial begin
      #(20 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", {busy, sts_irq, irq_set, proc_req}, 0, "flags in reset");
      chk("R10", addr_q, 0, "address in reset");
      rst_n = 1;
      for (int i = 0; i < 512; i++) begin
         @(negedge clk); bw_ram_we = 1; bw_addr = 9'(i); bw_data = 8'(i * 13 + 5);
      end
      @(negedge clk); bw_ram_we = 0;

      xfer(0, 32'h13, 0, 0, 0, 0);               // R4 inbound, plain
      xfer(1, 32'h45, 8'h21, 0, 0, 0);           // R5 outbound
      clear_sts();                               // R8
      xfer(0, 32'hFFFF_FFE5, 0, 0, 1, 0);        // R4 negative zeros, R9 poke
      xfer(1, 32'hFFFF_FFF3, 8'h90, 0, 0, 0);    // R5 negative skip
      xfer(0, 32'h100, 0, 0, 0, 1);              // R8 collide, equal-to-limit accepted
      clear_sts();

      // R3 drop of a too-high address
      @(negedge clk); addr_we = 1; addr_wdata = 32'h105;
      @(negedge clk); addr_we = 0; go_from_ram = 1;
      @(negedge clk); go_from_ram = 0;
      repeat (4) @(negedge clk);
      chk("R3", {30'h0, busy, sts_irq}, 0, "dropped request quiet");
      chk("R3", addr_q, 32'h105, "dropped address untouched");
      @(negedge clk); addr_we = 1; addr_wdata = 32'h7FFF_FFF8;
      @(negedge clk); addr_we = 0; go_to_ram = 1;
      @(negedge clk); go_to_ram = 0;
      chk("R3", {31'h0, busy}, 0, "large address dropped");

      xfer(1, 32'h20, 8'h33, 1, 0, 0);           // R9 both strobes -> outbound
      repeat (4) @(negedge clk);
      chk("R1", exp_ra.size() + exp_sa.size(), 0, "scoreboard drained");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule